// File: doc/BRIEF.md
# Suspend Wakeup Controller

This block decides when a suspended USB-attached network device may ask the host to resume. It watches eight general-purpose wake pins, a pulse from a magic-packet detector, a pulse from a wake-pattern matcher and the network link level. A programmed suspend level decides which of these sources are allowed to count. When an allowed source fires during suspend, the block raises a sticky remote-wakeup request and records the sources that caused it.

Software chooses one of three suspend levels while the device is running, then asks the block to enter suspend. The MAC clock enable drops for the whole time the device is suspended. The host ends the suspend with a resume acknowledge. That pulse clears the request and restores the clock. The reason register keeps its value until the next suspend entry, so it can be read after resume.

Top module: `wake_ctrl`

## Requirements
- R1: After reset, wake_req is 0, wake_reason is 0 and mac_clk_en is 1. The suspend level is 2 until software writes another level.
- R2: Level codes are 0, 1 and 2 on mode_sel. A write (mode_wr high) takes effect only while running. A write of code 3 is ignored, and so is any write made while suspended.
- R3: In level 0, GPIO, wake-pattern (wol_pulse) and magic-packet (magic_pulse) events may wake the host. A link change has no effect in this level.
- R4: In level 1, only GPIO events and link changes may wake the host. wol_pulse and magic_pulse are ignored.
- R5: In level 2, only a GPIO assertion may wake the host.
- R6: Each GPIO pin passes through two synchronizing flops. It counts only when its gpio_en bit is 1. It is asserted when the synchronized level XOR its gpio_pol bit is 1, so pol=1 means active-low. wake_req rises on the third rising edge after the pin changes.
- R7: A link change is detected when the synchronized link level differs from the level captured at suspend entry. wake_req rises on the third rising edge after link_in changes.
- R8: wake_req is sticky and stays high until resume_ack. resume_ack in any suspended state returns the block to running on the next edge, and wake_req is 0 after that edge.
- R9: wake_reason bits [7:0] are the GPIO pins that fired, bit 8 is wol, bit 9 is magic and bit 10 is link. It holds the allowed events of the first wake cycle only. Later events and events that are not allowed are not recorded. It is cleared at suspend entry.
- R10: mac_clk_en is 0 from the edge that enters suspend until the edge that takes resume_ack.
- R11: Events that arrive while running are ignored and raise no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpio_in | input | 8 | Asynchronous GPIO wake pins |
| gpio_en | input | 8 | Per-pin wake enable |
| gpio_pol | input | 8 | Per-pin polarity, 1 = active-low |
| magic_pulse | input | 1 | One-cycle magic-packet detect |
| wol_pulse | input | 1 | One-cycle wake-pattern match |
| link_in | input | 1 | Asynchronous link-state level |
| mode_wr | input | 1 | Strobe to load mode_sel |
| mode_sel | input | 2 | Suspend level code |
| susp_req | input | 1 | Enter suspend |
| resume_ack | input | 1 | Host resume, clears the request |
| wake_req | output | 1 | Sticky remote-wakeup request |
| wake_reason | output | 11 | Sources of the first wake |
| mac_clk_en | output | 1 | MAC clock-gate enable |

## Verification
Each suspend level is tried with every source type alone. This separates allowed sources from ignored ones per level. Mixed patterns fire a fast pulse source and a slow synchronized source at different cycles, which shows that only the first wake cycle is recorded. A GPIO event and a link change that land in the same cycle show that simultaneous sources merge. Active-low pins, disabled pins and enabled pins are mixed to separate the enable mask from the polarity bits. Directed cases cover the default level, illegal and late mode writes, events seen while running, and a resume with no wake.

// File: rtl/wake_pkg.sv
package wake_pkg;
  typedef enum logic [1:0] {
    LVL0 = 2'd0,
    LVL1 = 2'd1,
    LVL2 = 2'd2
  } susp_lvl_e;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_WOKE  = 2'd2
  } wake_st_e;

  // Which source classes the current level lets through
  typedef struct packed {
    logic gpio;
    logic link;
    logic magic;
    logic wol;
  } allow_t;

  localparam int NUM_NET_SRC = 3;  // wol, magic, link above the GPIO bits
endpackage

// File: rtl/wake_gpio_front.sv
module wake_gpio_front #(
  parameter int NPIN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_in,
  input  logic [NPIN-1:0] pin_en,
  input  logic [NPIN-1:0] pin_pol,
  output logic [NPIN-1:0] pin_hit
);
  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic meta_q, sync_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
      end else begin
        meta_q <= pin_in[i];
        sync_q <= meta_q;
      end
    end
    assign pin_hit[i] = pin_en[i] & (sync_q ^ pin_pol[i]);
  end
endmodule

// File: rtl/wake_link_watch.sv
module wake_link_watch (
  input  logic clk,
  input  logic rst_n,
  input  logic link_in,
  input  logic capture,
  output logic changed
);
  logic meta_q, sync_q, ref_q, ref_d;

  always_comb begin
    ref_d = ref_q;
    if (capture) ref_d = sync_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      ref_q  <= 1'b0;
    end else begin
      meta_q <= link_in;
      sync_q <= meta_q;
      ref_q  <= ref_d;
    end
  end

  assign changed = sync_q ^ ref_q;

  // R7: right after the reference is taken, it equals the level it was taken from
  assert_ref_taken_R7: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (ref_q == $past(sync_q)));
endmodule

// File: rtl/wake_policy.sv
module wake_policy
  import wake_pkg::*;
(
  input  susp_lvl_e lvl,
  output allow_t    allow
);
  always_comb begin
    allow = '0;
    unique case (lvl)
      LVL0:    begin allow.gpio = 1'b1; allow.wol  = 1'b1; allow.magic = 1'b1; end
      LVL1:    begin allow.gpio = 1'b1; allow.link = 1'b1; end
      default: begin allow.gpio = 1'b1; end
    endcase
  end
endmodule

// File: rtl/wake_ctrl.sv
module wake_ctrl
  import wake_pkg::*;
#(
  parameter int NGPIO = 8,
  localparam int RW = NGPIO + NUM_NET_SRC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NGPIO-1:0] gpio_in,
  input  logic [NGPIO-1:0] gpio_en,
  input  logic [NGPIO-1:0] gpio_pol,
  input  logic             magic_pulse,
  input  logic             wol_pulse,
  input  logic             link_in,
  input  logic             mode_wr,
  input  logic [1:0]       mode_sel,
  input  logic             susp_req,
  input  logic             resume_ack,
  output logic             wake_req,
  output logic [RW-1:0]    wake_reason,
  output logic             mac_clk_en
);
  wake_st_e       state_q, state_d;
  susp_lvl_e      lvl_q, lvl_d;
  logic [RW-1:0]  reason_q, reason_d;
  logic           req_q, req_d;
  logic           capture, link_chg;
  logic [NGPIO-1:0] pin_hit, gpio_ok;
  logic           wol_ok, magic_ok, link_ok, any_ok;
  allow_t         allow;

  wake_gpio_front #(.NPIN(NGPIO)) i_gpio (
    .clk(clk), .rst_n(rst_n), .pin_in(gpio_in), .pin_en(gpio_en),
    .pin_pol(gpio_pol), .pin_hit(pin_hit));

  wake_link_watch i_link (
    .clk(clk), .rst_n(rst_n), .link_in(link_in), .capture(capture),
    .changed(link_chg));

  wake_policy i_policy (.lvl(lvl_q), .allow(allow));

  assign gpio_ok  = allow.gpio ? pin_hit : '0;
  assign wol_ok   = allow.wol   & wol_pulse;
  assign magic_ok = allow.magic & magic_pulse;
  assign link_ok  = allow.link  & link_chg;
  assign any_ok   = (|gpio_ok) | wol_ok | magic_ok | link_ok;

  always_comb begin
    state_d  = state_q;
    lvl_d    = lvl_q;
    reason_d = reason_q;
    req_d    = req_q;
    capture  = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (mode_wr && mode_sel != 2'd3) lvl_d = susp_lvl_e'(mode_sel);
        if (susp_req) begin
          state_d  = ST_SLEEP;
          reason_d = '0;
          capture  = 1'b1;
        end
      end
      ST_SLEEP: begin
        if (resume_ack) begin
          state_d = ST_RUN;
        end else if (any_ok) begin
          state_d  = ST_WOKE;
          req_d    = 1'b1;
          reason_d = {link_ok, magic_ok, wol_ok, gpio_ok};
        end
      end
      default: begin
        if (resume_ack) begin
          state_d = ST_RUN;
          req_d   = 1'b0;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_RUN;
      lvl_q    <= LVL2;
      reason_q <= '0;
      req_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      lvl_q    <= lvl_d;
      reason_q <= reason_d;
      req_q    <= req_d;
    end
  end

  assign wake_req    = req_q;
  assign wake_reason = reason_q;
  assign mac_clk_en  = (state_q == ST_RUN);

  assert_sticky_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_req && !resume_ack) |=> wake_req);
  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    resume_ack |=> !wake_req);
  assert_req_gates_clk_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> !mac_clk_en);
  assert_reason_on_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_req) |-> (wake_reason != '0));
  assert_reason_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_req && $past(wake_req)) |-> $stable(wake_reason));
  assert_lvl2_gpio_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q == LVL2) |-> (allow == 4'b1000));
  assert_lvl_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q != 2'd3);
  assert_run_no_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_clk_en && !$past(resume_ack)) |-> !wake_req);
endmodule

// File: tb/test_wake_ctrl.sv
module test_wake_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] gpio_in = '0, gpio_en = '0, gpio_pol = '0;
  logic magic_pulse = 0, wol_pulse = 0, link_in = 0;
  logic mode_wr = 0, susp_req = 0, resume_ack = 0;
  logic [1:0] mode_sel = '0;
  logic wake_req, mac_clk_en;
  logic [10:0] wake_reason;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wake_ctrl i_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .gpio_in(gpio_in), .gpio_en(gpio_en),
    .gpio_pol(gpio_pol), .magic_pulse(magic_pulse), .wol_pulse(wol_pulse),
    .link_in(link_in), .mode_wr(mode_wr), .mode_sel(mode_sel),
    .susp_req(susp_req), .resume_ack(resume_ack), .wake_req(wake_req),
    .wake_reason(wake_reason), .mac_clk_en(mac_clk_en));

  // {mode, en, pol, val, magic, wol, linkflip, exp_req, exp_reason}
  localparam logic [40:0] VEC [NV] = '{
    {2'd2, 8'hFF, 8'h00, 8'h01, 1'b0, 1'b0, 1'b0, 1'b1, 11'h001}, // R5 gpio ok
    {2'd2, 8'hFF, 8'h00, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 11'h000}, // R5 net ignored
    {2'd0, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 11'h200}, // R3 magic
    {2'd0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 11'h100}, // R3 wol
    {2'd0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 11'h000}, // R3 link ignored
    {2'd1, 8'h00, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 11'h000}, // R4 pulses ignored
    {2'd1, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 11'h400}, // R4 R7 link
    {2'd1, 8'hF0, 8'h00, 8'h0F, 1'b0, 1'b0, 1'b0, 1'b0, 11'h000}, // R6 disabled pins
    {2'd0, 8'h81, 8'h81, 8'h81, 1'b0, 1'b0, 1'b0, 1'b1, 11'h081}, // R6 active-low
    {2'd0, 8'hFF, 8'h00, 8'h24, 1'b1, 1'b1, 1'b0, 1'b1, 11'h300}, // R9 first cycle only
    {2'd1, 8'h02, 8'h00, 8'h06, 1'b0, 1'b0, 1'b1, 1'b1, 11'h402}, // R9 merge
    {2'd2, 8'h80, 8'h80, 8'h80, 1'b0, 1'b0, 1'b0, 1'b1, 11'h080}  // R6 R5
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_mode(input logic [1:0] m);
    mode_wr = 1; mode_sel = m; tick(1); mode_wr = 0;
  endtask

  task automatic enter_susp();
    susp_req = 1; tick(1); susp_req = 0;
  endtask

  task automatic do_resume();
    resume_ack = 1; tick(1); resume_ack = 0;
  endtask

  task automatic pulse(input bit m, input bit w);
    magic_pulse = m; wol_pulse = w; tick(1); magic_pulse = 0; wol_pulse = 0;
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000 && !done) begin
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=<20000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    tick(2);
    rst_n = 1;
    tick(1);
    check(wake_req == 0, "R1 req after reset", 32'(wake_req), 0);
    check(wake_reason == 0, "R1 reason after reset", 32'(wake_reason), 0);
    check(mac_clk_en == 1, "R1 clk after reset", 32'(mac_clk_en), 1);

    // R1 default level 2: magic ignored, GPIO accepted
    gpio_en = 8'h01; tick(3);
    enter_susp(); tick(2);
    pulse(1, 0); tick(3);
    check(wake_req == 0, "R1 default level ignores magic", 32'(wake_req), 0);
    gpio_in = 8'h01; tick(4);
    check(wake_req == 1, "R1 default level gpio wake", 32'(wake_req), 1);
    check(wake_reason == 11'h001, "R1 reason", 32'(wake_reason), 32'h001);
    do_resume();
    gpio_in = 0; gpio_en = 0; tick(3);

    // R11 events while running ignored
    set_mode(2'd0);
    pulse(1, 1); tick(3);
    check(wake_req == 0, "R11 running ignores events", 32'(wake_req), 0);
    enter_susp(); tick(4);
    check(wake_req == 0 && wake_reason == 0, "R11 nothing latched",
          32'(wake_reason), 0);
    do_resume();

    // table walk
    for (int v = 0; v < NV; v++) begin
      logic [40:0] e;
      e = VEC[v];
      set_mode(e[40:39]);
      gpio_en = e[38:31]; gpio_pol = e[30:23]; gpio_in = e[30:23];
      tick(3);
      enter_susp();
      check(mac_clk_en == 0, $sformatf("R10 vec %0d clk gated", v), 32'(mac_clk_en), 0);
      tick(2);
      gpio_in = e[30:23] ^ e[22:15];
      if (e[12]) link_in = ~link_in;
      pulse(e[14], e[13]);
      tick(3);
      check(wake_req == e[11], $sformatf("R3 R4 R5 R6 R7 vec %0d req", v),
            32'(wake_req), 32'(e[11]));
      check(wake_reason == e[10:0], $sformatf("R9 vec %0d reason", v),
            32'(wake_reason), 32'(e[10:0]));
      do_resume();
      check(wake_req == 0 && mac_clk_en == 1, $sformatf("R8 R10 vec %0d resume", v),
            {30'd0, wake_req, mac_clk_en}, 1);
      gpio_in = gpio_pol; tick(3);
    end
    gpio_en = 0; gpio_pol = 0; gpio_in = 0; tick(3);

    // R2 code 3 ignored
    set_mode(2'd0); set_mode(2'd3);
    enter_susp(); tick(1);
    pulse(1, 0);
    check(wake_req == 1 && wake_reason == 11'h200, "R2 code 3 ignored",
          32'(wake_reason), 32'h200);
    do_resume();

    // R2 write while suspended ignored
    set_mode(2'd2);
    gpio_en = 8'h10; tick(3);
    enter_susp();
    set_mode(2'd0); tick(1);
    pulse(1, 0); tick(2);
    check(wake_req == 0, "R2 write in suspend ignored", 32'(wake_req), 0);
    gpio_in = 8'h10; tick(4);
    check(wake_reason == 11'h010, "R2 gpio still wakes", 32'(wake_reason), 32'h010);
    do_resume();
    gpio_in = 0; gpio_en = 0; tick(3);

    // R8 R9 sticky and first only
    set_mode(2'd0);
    enter_susp(); tick(1);
    pulse(0, 1); tick(20);
    pulse(1, 0); tick(2);
    check(wake_req == 1, "R8 sticky request", 32'(wake_req), 1);
    check(wake_reason == 11'h100, "R9 later event not recorded",
          32'(wake_reason), 32'h100);
    do_resume();
    check(wake_reason == 11'h100, "R9 reason kept after resume",
          32'(wake_reason), 32'h100);

    // R8 resume with no wake
    enter_susp(); tick(3);
    check(wake_reason == 0, "R9 cleared at entry", 32'(wake_reason), 0);
    do_resume();
    check(mac_clk_en == 1 && wake_req == 0, "R8 resume without wake",
          {30'd0, wake_req, mac_clk_en}, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule